// File: doc/BRIEF.md
# Carry-Save Montgomery Modular Exponentiation Sequencer

This block raises a base to a secret power modulo an odd modulus using the right-to-left binary method on top of two radix-2 Montgomery multipliers. Every intermediate value, the running square and the running product alike, stays in redundant carry-save form (two vectors whose sum is the value). No word-wide carry-propagate adder exists anywhere in the datapath, so the clock period is independent of the modulus width. A single bit-serial addition folds the final pair into ordinary binary once the whole exponentiation has finished.

The caller supplies the base, the modulus, the exponent with its bit count, and a domain-entry constant computed elsewhere. After a start pulse the block runs a pre-processing slot, one slot per exponent bit, one post-processing slot and a serial conversion phase, and then raises a one-cycle completion pulse with the result on its output. Within each slot the squaring and the conditional multiply run side by side on the two multipliers. With `W = K_W + 2` Montgomery iterations per product, every slot lasts `W + 2` cycles.

Top module: `mont_exp_seq`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `result_o` is 0.
- R2: For an odd modulus n with 3 <= n < 2^K_W, a base c with 1 <= c < n and gcd(c, n) = 1, and the constant input equal to 2^(2W) mod n, the result equals c^e mod n. Here e is the exponent formed by bits `[len-1:0]` of `exp_i`, and W = K_W + 2.
- R3: Operands are captured on the clock edge where `start` is high while the block is idle. Changes on the operand inputs after that edge do not affect the run in progress.
- R4: A `start` pulse while `busy_o` is high is ignored. The running result and its latency are unchanged.
- R5: `done_o` rises exactly (len + 2)(K_W + 4) + K_W + 1 cycles after the capturing edge.
- R6: `busy_o` is high from the cycle after the capturing edge through the cycle in which `done_o` is high. `done_o` is high for exactly one cycle, and both are low in the following cycle.
- R7: `result_o` holds its value from the `done_o` cycle until the conversion phase of the next run.
- R8: During a loop slot whose exponent bit is 0, the running product is left unchanged. Only the squaring advances.
- R9: Exponent bits at position `len` and above have no effect on the result.
- R10: With `exp_len_i` = 0 the result is 1.
- R11: In every multiplier iteration the five-operand carry-save total is even, so halving it loses no bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| base_i | input | K_W | Base c |
| mod_i | input | K_W | Odd modulus n |
| rsq_i | input | K_W | Constant 2^(2W) mod n |
| exp_i | input | E_W | Exponent bits, LSB first in time |
| exp_len_i | input | $clog2(E_W+1) | Number of exponent bits used |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | K_W | c^e mod n in binary |

## Verification
The squaring of the running power and the conditional multiply into the accumulator share every loop slot. Both read the same pre-squaring power and both write back on the same closing edge. The bench provokes this overlap with exponents that mix runs of ones and isolated zeros: 3 and 65537, all-ones patterns and random values. It judges the outcome by comparing the binary result against a reference square-and-multiply computed in the bench, and the completion cycle against the slot-count formula. Any stale or early operand in the shared slot shows up as a wrong residue.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LOOP,
    ST_POST,
    ST_CONV,
    ST_DONE
  } mexp_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/mexp_csa52.sv
module mexp_csa52 #(
  parameter int WD = 19
) (
  input  logic [WD-1:0] x1_i,
  input  logic [WD-1:0] x2_i,
  input  logic [WD-1:0] x3_i,
  input  logic [WD-1:0] x4_i,
  input  logic [WD-1:0] x5_i,
  output logic [WD-1:0] sum_o,
  output logic [WD-1:0] cy_o
);
  // three 3:2 levels; total = sum_o + 2*cy_o
  logic [WD-1:0] l1_s, l1_c, l2_s, l2_c;

  always_comb begin
    l1_s  = x1_i ^ x2_i ^ x3_i;
    l1_c  = ((x1_i & x2_i) | (x1_i & x3_i) | (x2_i & x3_i)) << 1;
    l2_s  = l1_s ^ l1_c ^ x4_i;
    l2_c  = ((l1_s & l1_c) | (l1_s & x4_i) | (l1_c & x4_i)) << 1;
    sum_o = l2_s ^ l2_c ^ x5_i;
    cy_o  = (l2_s & l2_c) | (l2_s & x5_i) | (l2_c & x5_i);
  end
endmodule

// File: rtl/mexp_mont_mul.sv
module mexp_mont_mul
  import mexp_pkg::*;
#(
  parameter  int K_W = 16,
  localparam int CW  = K_W + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [CW-1:0] a1_i,
  input  logic [CW-1:0] a2_i,
  input  logic [CW-1:0] b1_i,
  input  logic [CW-1:0] b2_i,
  input  logic [CW-1:0] n_i,
  output logic [CW-1:0] s1_o,
  output logic [CW-1:0] s2_o
);
  logic [CW-1:0] a1_q, a2_q, b1_q, b2_q, s1_q, s2_q;
  logic          acy_q;
  logic [CW-1:0] a1_d, a2_d, b1_d, b2_d, s1_d, s2_d;
  logic          acy_d;
  logic          a_bit, q_bit;
  logic [CW-1:0] x3, x4, x5, csa_sum, csa_cy;

  // serial full adder recovers one multiplier digit per iteration
  always_comb begin
    a_bit = a1_q[0] ^ a2_q[0] ^ acy_q;
    q_bit = s1_q[0] ^ s2_q[0] ^ (a_bit & (b1_q[0] ^ b2_q[0]));
    x3    = a_bit ? b1_q : '0;
    x4    = a_bit ? b2_q : '0;
    x5    = q_bit ? n_i  : '0;
  end

  mexp_csa52 #(.WD(CW)) u_csa (
    .x1_i (s1_q),
    .x2_i (s2_q),
    .x3_i (x3),
    .x4_i (x4),
    .x5_i (x5),
    .sum_o(csa_sum),
    .cy_o (csa_cy)
  );

  always_comb begin
    a1_d  = a1_q;
    a2_d  = a2_q;
    acy_d = acy_q;
    b1_d  = b1_q;
    b2_d  = b2_q;
    s1_d  = s1_q;
    s2_d  = s2_q;
    if (load) begin
      a1_d  = a1_i;
      a2_d  = a2_i;
      acy_d = 1'b0;
      b1_d  = b1_i;
      b2_d  = b2_i;
      s1_d  = '0;
      s2_d  = '0;
    end else if (step) begin
      a1_d  = a1_q >> 1;
      a2_d  = a2_q >> 1;
      acy_d = maj3(a1_q[0], a2_q[0], acy_q);
      s1_d  = {1'b0, csa_sum[CW-1:1]};
      s2_d  = csa_cy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1_q  <= '0;
      a2_q  <= '0;
      acy_q <= 1'b0;
      b1_q  <= '0;
      b2_q  <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
    end else if (load || step) begin
      a1_q  <= a1_d;
      a2_q  <= a2_d;
      acy_q <= acy_d;
      b1_q  <= b1_d;
      b2_q  <= b2_d;
      s1_q  <= s1_d;
      s2_q  <= s2_d;
    end
  end

  assign s1_o = s1_q;
  assign s2_o = s2_q;

  // R11: quotient bit must make the carry-save total even before halving
  a_r11_even_total: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (csa_sum[0] == 1'b0));

endmodule

// File: rtl/mexp_ser_add.sv
module mexp_ser_add
  import mexp_pkg::*;
#(
  parameter int K_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [K_W-1:0] x1_i,
  input  logic [K_W-1:0] x2_i,
  output logic [K_W-1:0] sum_o
);
  logic [K_W-1:0] x1_q, x2_q, acc_q, x1_d, x2_d, acc_d;
  logic           cy_q, cy_d;

  always_comb begin
    x1_d  = x1_q;
    x2_d  = x2_q;
    cy_d  = cy_q;
    acc_d = acc_q;
    if (load) begin
      x1_d = x1_i;
      x2_d = x2_i;
      cy_d = 1'b0;
    end else if (step) begin
      x1_d  = x1_q >> 1;
      x2_d  = x2_q >> 1;
      cy_d  = maj3(x1_q[0], x2_q[0], cy_q);
      acc_d = {x1_q[0] ^ x2_q[0] ^ cy_q, acc_q[K_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q  <= '0;
      x2_q  <= '0;
      cy_q  <= 1'b0;
      acc_q <= '0;
    end else if (load || step) begin
      x1_q  <= x1_d;
      x2_q  <= x2_d;
      cy_q  <= cy_d;
      acc_q <= acc_d;
    end
  end

  assign sum_o = acc_q;

endmodule

// File: rtl/mont_exp_seq.sv
module mont_exp_seq
  import mexp_pkg::*;
#(
  parameter  int K_W = 16,
  parameter  int E_W = 17,
  localparam int LW  = $clog2(E_W + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [K_W-1:0] base_i,
  input  logic [K_W-1:0] mod_i,
  input  logic [K_W-1:0] rsq_i,
  input  logic [E_W-1:0] exp_i,
  input  logic [LW-1:0]  exp_len_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [K_W-1:0] result_o
);
  localparam int CW        = K_W + 3;
  localparam int W         = K_W + 2;
  localparam int SLOT_LAST = W + 1;
  localparam int CNT_W     = $clog2(SLOT_LAST + 1);

  mexp_state_t    state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LW-1:0]  idx_q, idx_d, len_q;
  logic [E_W-1:0] dsh_q, dsh_d;
  logic [K_W-1:0] c_q, n_q, k_q;
  logic [CW-1:0]  p1_q, p2_q, r1_q, r2_q;
  logic           lat_en, in_slot, slot_end, conv_end;
  logic           p_we, r_we, mul_load, mul_step, cv_load, cv_step;
  logic [CW-1:0]  pa1, pa2, pb1, pb2, ra1, ra2, rb1, rb2;
  logic [CW-1:0]  mp_s1, mp_s2, mr_s1, mr_s2, n_ext, k_ext, c_ext, one_ext;

  assign n_ext   = CW'(n_q);
  assign k_ext   = CW'(k_q);
  assign c_ext   = CW'(c_q);
  assign one_ext = CW'(1);

  always_comb begin
    lat_en   = (state_q == ST_IDLE) && start;
    in_slot  = (state_q == ST_PRE) || (state_q == ST_LOOP) || (state_q == ST_POST);
    slot_end = in_slot && (cnt_q == CNT_W'(SLOT_LAST));
    conv_end = (state_q == ST_CONV) && (cnt_q == CNT_W'(K_W));
    mul_load = in_slot && (cnt_q == '0);
    mul_step = in_slot && (cnt_q != '0) && !slot_end;
    cv_load  = (state_q == ST_CONV) && (cnt_q == '0);
    cv_step  = (state_q == ST_CONV) && (cnt_q != '0);
    p_we     = slot_end && ((state_q == ST_PRE) || (state_q == ST_LOOP));
    r_we     = slot_end && ((state_q == ST_PRE) || (state_q == ST_POST) ||
                            ((state_q == ST_LOOP) && dsh_q[0]));
  end

  // operand steering for the two multipliers
  always_comb begin
    pa1 = '0; pa2 = '0; pb1 = '0; pb2 = '0;
    ra1 = '0; ra2 = '0; rb1 = '0; rb2 = '0;
    case (state_q)
      ST_PRE: begin
        pa1 = k_ext; pb1 = c_ext;
        ra1 = k_ext; rb1 = one_ext;
      end
      ST_LOOP: begin
        pa1 = p1_q; pa2 = p2_q; pb1 = p1_q; pb2 = p2_q;
        ra1 = r1_q; ra2 = r2_q; rb1 = p1_q; rb2 = p2_q;
      end
      ST_POST: begin
        ra1 = one_ext; rb1 = r1_q; rb2 = r2_q;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    dsh_d   = dsh_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_PRE;
          cnt_d   = '0;
          idx_d   = '0;
          dsh_d   = exp_i;
        end
      end
      ST_PRE, ST_LOOP, ST_POST: begin
        if (slot_end) begin
          cnt_d = '0;
          if (state_q == ST_PRE) begin
            state_d = (len_q == '0) ? ST_POST : ST_LOOP;
          end else if (state_q == ST_LOOP) begin
            dsh_d = dsh_q >> 1;
            idx_d = idx_q + 1'b1;
            if (idx_q == LW'(len_q - 1'b1)) state_d = ST_POST;
          end else begin
            state_d = ST_CONV;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CONV: begin
        if (conv_end) begin
          state_d = ST_DONE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      dsh_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      dsh_q   <= dsh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q   <= '0;
      n_q   <= '0;
      k_q   <= '0;
      len_q <= '0;
    end else if (lat_en) begin
      c_q   <= base_i;
      n_q   <= mod_i;
      k_q   <= rsq_i;
      len_q <= exp_len_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_q <= '0;
      p2_q <= '0;
    end else if (p_we) begin
      p1_q <= mp_s1;
      p2_q <= mp_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= '0;
      r2_q <= '0;
    end else if (r_we) begin
      r1_q <= mr_s1;
      r2_q <= mr_s2;
    end
  end

  mexp_mont_mul #(.K_W(K_W)) u_mul_sq (
    .clk (clk), .rst_n(rst_n), .load(mul_load), .step(mul_step),
    .a1_i(pa1), .a2_i(pa2), .b1_i(pb1), .b2_i(pb2), .n_i(n_ext),
    .s1_o(mp_s1), .s2_o(mp_s2)
  );

  mexp_mont_mul #(.K_W(K_W)) u_mul_acc (
    .clk (clk), .rst_n(rst_n), .load(mul_load), .step(mul_step),
    .a1_i(ra1), .a2_i(ra2), .b1_i(rb1), .b2_i(rb2), .n_i(n_ext),
    .s1_o(mr_s1), .s2_o(mr_s2)
  );

  mexp_ser_add #(.K_W(K_W)) u_fold (
    .clk  (clk), .rst_n(rst_n), .load(cv_load), .step(cv_step),
    .x1_i (r1_q[K_W-1:0]), .x2_i(r2_q[K_W-1:0]),
    .sum_o(result_o)
  );

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r4_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start) |=> ($stable(n_q) && $stable(c_q) && $stable(len_q)));

  a_r8_acc_held_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_LOOP) && slot_end && !dsh_q[0]) |=> ($stable(r1_q) && $stable(r2_q)));

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_CONV) |=> $stable(result_o));

  a_r5_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_slot |-> (cnt_q <= CNT_W'(SLOT_LAST)));

endmodule

// File: tb/sim_mont_exp_seq.sv
module sim_mont_exp_seq;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 16;
  localparam int EW = 17;
  localparam int LW = $clog2(EW + 1);
  localparam int WI = KW + 2;

  logic          clk, rst_n, start, busy, done;
  logic [KW-1:0] base, modn, rsq, result;
  logic [EW-1:0] expo;
  logic [LW-1:0] elen;
  int n_tests, n_fail;

  mont_exp_seq #(.K_W(KW), .E_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_i(base), .mod_i(modn),
    .rsq_i(rsq), .exp_i(expo), .exp_len_i(elen), .busy_o(busy),
    .done_o(done), .result_o(result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exv);
    n_tests++;
    if (act != exv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exv);
    end
  endtask

  function automatic longint ref_pow(longint c, longint d, int len, longint n);
    longint r = 1 % n;
    longint b = c % n;
    for (int i = 0; i < len; i++) begin
      if (d[i]) r = (r * b) % n;
      b = (b * b) % n;
    end
    return r;
  endfunction

  function automatic longint dom_const(longint n);
    longint x = 1;
    for (int i = 0; i < 2 * WI; i++) x = (x * 2) % n;
    return x;
  endfunction

  function automatic longint gcd(longint a, longint b);
    longint t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  // mode 0 plain, 1 scramble inputs after capture (R3), 2 restart while busy (R4)
  task automatic run_one(input string tag, input longint c, input longint n,
                         input longint d, input int len, input int mode);
    longint exv;
    int cyc;
    logic [KW-1:0] held;
    exv = ref_pow(c, d, len, n);
    @(negedge clk);
    base = KW'(c); modn = KW'(n); rsq = KW'(dom_const(n));
    expo = EW'(d); elen = LW'(len); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    chk({tag, " R6 busy after start"}, busy, 1);
    if (mode == 1) begin
      base = ~base; modn = 16'h0003; rsq = 16'h1234; expo = ~expo; elen = 1;
    end
    while (!done && cyc < 2000) begin
      if (mode == 2 && cyc == 40) begin
        start = 1'b1; base = 16'h0002; modn = 16'h0007; expo = '1; elen = 3;
      end
      if (mode == 2 && cyc == 41) start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk({tag, " R5 latency"}, cyc, (len + 2) * (KW + 4) + KW + 1);
    chk({tag, " result"}, result, exv);
    held = result;
    @(negedge clk);
    chk({tag, " R6 done low after pulse"}, done, 0);
    chk({tag, " R6 busy low after done"}, busy, 0);
    repeat (2) @(negedge clk);
    chk({tag, " R7 result held"}, result, held);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    longint n, c, d;
    int len;
    void'($urandom(32'd7741));
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; start = 1'b0; base = '0; modn = '0; rsq = '0; expo = '0; elen = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy reset", busy, 0);
    chk("R1 done reset", done, 0);
    chk("R1 result reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_one("R2 exp1", 5, 13, 1, 1, 0);
    run_one("R2 exp3", 1234, 40961, 3, 2, 0);
    run_one("R8 exp65537", 4321, 65521, 65537, 17, 0);
    run_one("R2 exp65537 wide", 65534, 65535 - 0, 65537, 17, 0);
    run_one("R10 len0", 77, 1001, 17'h1FFFF, 0, 0);
    run_one("R9 upper bits", 3, 97, 17'h1FFFF, 5, 0);
    run_one("R2 small modulus", 2, 3, 17'h0000B, 4, 0);
    run_one("R2 base one", 1, 30001, 17'h15555, 17, 0);
    run_one("R2 base n-1", 30000, 30001, 17'h0000F, 4, 0);
    run_one("R8 sparse", 999, 65533, 17'h10100, 17, 0);
    run_one("R3 inputs change", 4567, 50001, 17'h0BEEF, 16, 1);
    run_one("R4 restart ignored", 4567, 50001, 17'h0BEEF, 16, 2);

    for (int k = 0; k < 22; k++) begin
      n = longint'(($urandom % 65533) + 3) | 1;
      if (n > 65535) n = 65535;
      do c = longint'($urandom % (n - 1)) + 1; while (gcd(c, n) != 1);
      d = longint'($urandom % (1 << EW));
      len = int'($urandom % EW) + 1;
      run_one("R2 R9 random", c, n, d, len, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule